// File: doc/BRIEF.md
# Command Queue Ring Processor

The block empties a circular queue of 32-byte commands that software keeps in system memory. Software appends commands and then moves a write index. While enabled, the block reads each pending entry as four 64-bit beats over a single-outstanding memory read port. It classifies the opcode in the low byte of the first beat. Mapping and translation opcodes go to an external handler through a valid/ready offer, and the handler answers continue or stall with a done strobe. The block handles the synchronisation opcode and the invalidate-all opcode itself. It also skips any opcode it does not recognise.

Each completed command moves the read index forward by one and wraps at the queue depth. The queue depth is set by a page-count field. Errors are split into two classes. A failed memory beat, or a handler that answers stall, freezes the queue with a sticky stalled flag. A command with bad parameters is the handler's to drop, and the handler answers continue for it. Only reset clears the stalled flag.

Top module: `cq_ring_proc`

## Requirements
- R1: Entry n of the queue sits at byte address (base_pfn × 4096) + n × 32. Its four 64-bit beats are requested in order at offsets 0, 8, 16 and 24. A request holds its address until it is accepted, and the beats reach the handler as hnd_cmd, with beat k in bits [64k+63:64k].
- R2: The queue depth in entries is (size_fld + 1) × 128. After the command at index depth−1 completes, the read index returns to 0.
- R3: A new command starts only while en is high. Processing stops when rd_idx equals wr_idx.
- R4: If wr_idx or rd_idx is at or above the depth, no command starts, no memory request is made and rd_idx keeps its value.
- R5: If a memory beat returns with mem_rsp_err set, stalled goes high and rd_idx stays on that entry. The command is not offered to the handler.
- R6: The opcode is bits [7:0] of beat 0. Opcodes 0x03, 0x04, 0x08, 0x09, 0x0A, 0x0B and 0x0F are offered on the handler port with the entry address and the command. hnd_valid and hnd_opcode hold until hnd_ready is seen.
- R7: A handler done with hnd_stall low advances rd_idx. A handler done with hnd_stall high sets stalled and leaves rd_idx on the failing entry.
- R8: Opcode 0x05 (synchronise) is never offered to the handler and always advances rd_idx.
- R9: Opcode 0x0D (invalidate all) drives every bit of recalc high for exactly one cycle, is not offered to the handler, and then advances rd_idx.
- R10: Any other opcode is skipped. It is not offered to the handler and rd_idx advances.
- R11: Once stalled is high it stays high until reset. No further memory request or handler offer is made, whatever wr_idx does.
- R12: After reset, rd_idx is 0, stalled is 0, and no memory request, handler offer or recalc pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Global enable for command processing |
| size_fld | input | SIZE_W | Queue size in 4 KiB pages, minus one |
| base_pfn | input | PA_W-12 | Queue base address divided by 4096 |
| wr_idx | input | SIZE_W+7 | Software write index |
| rd_idx | output | SIZE_W+7 | Read index of the next command to process |
| stalled | output | 1 | Sticky stall flag |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_addr | output | PA_W | Byte address of the requested 64-bit beat |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response carries an error |
| hnd_valid | output | 1 | Command offered to the handler |
| hnd_ready | input | 1 | Handler accepts the offer |
| hnd_opcode | output | 8 | Opcode of the offered command |
| hnd_addr | output | PA_W | Byte address of the offered entry |
| hnd_cmd | output | 256 | All four beats of the offered command |
| hnd_done | input | 1 | Handler finished the accepted command |
| hnd_stall | input | 1 | With hnd_done: high means stall, low means continue |
| recalc | output | NCPU | Per-CPU priority recalculation pulse |

## Verification
An entry address computed with the wrong stride shows up on mem_rd_addr at the first request after the wrong rd_idx appears. A wrong depth shows up as a wrong rd_idx on the first wrap. A misclassified opcode shows up within a few cycles of the fourth beat, either as an unexpected handler offer or recalc pulse, or as one that should have come and did not. A stalled flag that was lost or set by mistake shows up as requests continuing or stopping at the wrong index, and the final rd_idx after each scenario differs from the value computed arithmetically.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int CMD_BEATS   = 4;
  localparam int BEAT_W      = 64;
  localparam int PAGE_SHIFT  = 12;
  localparam int ENTRY_SHIFT = 5;
  localparam int PAGE_ENTRY_LOG = PAGE_SHIFT - ENTRY_SHIFT;

  localparam logic [7:0] OPC_TRIGGER  = 8'h03;
  localparam logic [7:0] OPC_UNPEND   = 8'h04;
  localparam logic [7:0] OPC_SYNC     = 8'h05;
  localparam logic [7:0] OPC_MAP_DEV  = 8'h08;
  localparam logic [7:0] OPC_MAP_COL  = 8'h09;
  localparam logic [7:0] OPC_MAP_EVT  = 8'h0A;
  localparam logic [7:0] OPC_MAP_SELF = 8'h0B;
  localparam logic [7:0] OPC_INV_ALL  = 8'h0D;
  localparam logic [7:0] OPC_REMOVE   = 8'h0F;

  typedef enum logic [1:0] {
    KIND_HANDLER = 2'd0,
    KIND_SYNC    = 2'd1,
    KIND_BCAST   = 2'd2,
    KIND_SKIP    = 2'd3
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [7:0] opc);
    case (opc)
      OPC_TRIGGER, OPC_UNPEND, OPC_MAP_DEV, OPC_MAP_COL,
      OPC_MAP_EVT, OPC_MAP_SELF, OPC_REMOVE: return KIND_HANDLER;
      OPC_SYNC:                              return KIND_SYNC;
      OPC_INV_ALL:                           return KIND_BCAST;
      default:                               return KIND_SKIP;
    endcase
  endfunction
endpackage

// File: rtl/cq_ptr_unit.sv
module cq_ptr_unit #(
  parameter int SIZE_W = 8,
  localparam int IDX_W = SIZE_W + cq_pkg::PAGE_ENTRY_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SIZE_W-1:0] size_fld,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              busy,
  input  logic              advance,
  input  logic              stall_set,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              stalled,
  output logic              in_range,
  output logic              go
);
  function automatic logic [IDX_W:0] depth_of(input logic [SIZE_W-1:0] s);
    logic [IDX_W:0] pages;
    pages = (IDX_W+1)'(s) + (IDX_W+1)'(1);
    return pages << cq_pkg::PAGE_ENTRY_LOG;
  endfunction

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W:0]   depth);
    logic [IDX_W:0] n;
    n = {1'b0, idx} + (IDX_W+1)'(1);
    return (n == depth) ? '0 : n[IDX_W-1:0];
  endfunction

  logic [IDX_W:0] depth;

  assign depth    = depth_of(size_fld);
  assign in_range = ({1'b0, wr_idx} < depth) && ({1'b0, rd_idx} < depth);
  assign go       = en && !stalled && !busy && in_range && (wr_idx != rd_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      stalled <= 1'b0;
    end else begin
      if (advance)   rd_idx  <= next_idx(rd_idx, depth);
      if (stall_set) stalled <= 1'b1;
    end
  end
endmodule

// File: rtl/cq_fetch.sv
module cq_fetch #(
  parameter int PA_W  = 48,
  parameter int IDX_W = 15,
  localparam int PFN_W  = PA_W - cq_pkg::PAGE_SHIFT,
  localparam int BEAT_I = $clog2(cq_pkg::CMD_BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PFN_W-1:0]        base_pfn,
  input  logic [IDX_W-1:0]        idx,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [PA_W-1:0]         mem_rd_addr,
  input  logic                    mem_rsp_valid,
  input  logic [cq_pkg::BEAT_W-1:0] mem_rsp_data,
  input  logic                    mem_rsp_err,
  output logic [PA_W-1:0]         entry_addr,
  output logic [cq_pkg::CMD_BEATS*cq_pkg::BEAT_W-1:0] cmd,
  output logic                    done,
  output logic                    err
);
  function automatic logic [PA_W-1:0] entry_address(input logic [PFN_W-1:0] pfn,
                                                    input logic [IDX_W-1:0] i);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] off;
    base = {pfn, {cq_pkg::PAGE_SHIFT{1'b0}}};
    off  = PA_W'(i) << cq_pkg::ENTRY_SHIFT;
    return base + off;
  endfunction

  function automatic logic [PA_W-1:0] beat_address(input logic [PA_W-1:0] ea,
                                                   input logic [BEAT_I-1:0] b);
    return ea + (PA_W'(b) << 3);
  endfunction

  logic              active;
  logic              waiting;
  logic [BEAT_I-1:0] beat;
  logic              last_beat;
  logic [cq_pkg::CMD_BEATS-1:0][cq_pkg::BEAT_W-1:0] beats_q;

  assign last_beat    = (beat == BEAT_I'(cq_pkg::CMD_BEATS - 1));
  assign mem_rd_valid = active && !waiting;
  assign mem_rd_addr  = beat_address(entry_addr, beat);
  assign err          = active && waiting && mem_rsp_valid && mem_rsp_err;
  assign done         = active && waiting && mem_rsp_valid && !mem_rsp_err && last_beat;
  assign cmd          = beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      waiting    <= 1'b0;
      beat       <= '0;
      entry_addr <= '0;
      beats_q    <= '0;
    end else if (start) begin
      active     <= 1'b1;
      waiting    <= 1'b0;
      beat       <= '0;
      entry_addr <= entry_address(base_pfn, idx);
    end else if (active) begin
      if (!waiting) begin
        if (mem_rd_ready) waiting <= 1'b1;
      end else if (mem_rsp_valid) begin
        waiting <= 1'b0;
        if (mem_rsp_err) begin
          active <= 1'b0;
        end else begin
          beats_q[beat] <= mem_rsp_data;
          if (last_beat) active <= 1'b0;
          else           beat   <= beat + BEAT_I'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cq_dispatch.sv
module cq_dispatch #(
  parameter int PA_W = 48,
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      opcode,
  output logic            hnd_valid,
  input  logic            hnd_ready,
  output logic [7:0]      hnd_opcode,
  input  logic            hnd_done,
  input  logic            hnd_stall,
  output logic [NCPU-1:0] recalc,
  output logic            done,
  output logic            stall
);
  import cq_pkg::*;

  typedef enum logic [2:0] {
    D_IDLE  = 3'd0,
    D_OFFER = 3'd1,
    D_WAIT  = 3'd2,
    D_BCAST = 3'd3,
    D_PASS  = 3'd4
  } disp_state_e;

  disp_state_e state;
  logic [7:0]  opc_q;
  logic        bcast_now;

  assign hnd_valid  = (state == D_OFFER);
  assign hnd_opcode = opc_q;
  assign bcast_now  = (state == D_BCAST);
  assign done       = (state == D_PASS) || bcast_now || ((state == D_WAIT) && hnd_done);
  assign stall      = (state == D_WAIT) && hnd_done && hnd_stall;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign recalc[c] = bcast_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= D_IDLE;
      opc_q <= '0;
    end else begin
      case (state)
        D_IDLE: if (start) begin
          opc_q <= opcode;
          case (classify(opcode))
            KIND_HANDLER: state <= D_OFFER;
            KIND_BCAST:   state <= D_BCAST;
            default:      state <= D_PASS;
          endcase
        end
        D_OFFER: if (hnd_ready) state <= D_WAIT;
        D_WAIT:  if (hnd_done)  state <= D_IDLE;
        default: state <= D_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cq_ring_proc.sv
module cq_ring_proc #(
  parameter int PA_W   = 48,
  parameter int SIZE_W = 8,
  parameter int NCPU   = 4,
  localparam int IDX_W = SIZE_W + cq_pkg::PAGE_ENTRY_LOG,
  localparam int PFN_W = PA_W - cq_pkg::PAGE_SHIFT,
  localparam int CMD_W = cq_pkg::CMD_BEATS * cq_pkg::BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SIZE_W-1:0] size_fld,
  input  logic [PFN_W-1:0]  base_pfn,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              stalled,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              hnd_valid,
  input  logic              hnd_ready,
  output logic [7:0]        hnd_opcode,
  output logic [PA_W-1:0]   hnd_addr,
  output logic [CMD_W-1:0]  hnd_cmd,
  input  logic              hnd_done,
  input  logic              hnd_stall,
  output logic [NCPU-1:0]   recalc
);
  // named internal events
  logic busy;
  logic go;
  logic in_range;
  logic fetch_done;
  logic fetch_err;
  logic disp_done;
  logic disp_stall;
  logic advance;
  logic stall_set;
  logic [PA_W-1:0]  entry_addr;
  logic [CMD_W-1:0] cmd;

  assign advance   = disp_done && !disp_stall;
  assign stall_set = fetch_err || (disp_done && disp_stall);
  assign hnd_addr  = entry_addr;
  assign hnd_cmd   = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    busy <= 1'b0;
    else if (go)                   busy <= 1'b1;
    else if (advance || stall_set) busy <= 1'b0;
  end

  cq_ptr_unit #(.SIZE_W(SIZE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .en(en), .size_fld(size_fld), .wr_idx(wr_idx),
    .busy(busy), .advance(advance), .stall_set(stall_set),
    .rd_idx(rd_idx), .stalled(stalled), .in_range(in_range), .go(go)
  );

  cq_fetch #(.PA_W(PA_W), .IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(go), .base_pfn(base_pfn), .idx(rd_idx),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .entry_addr(entry_addr), .cmd(cmd), .done(fetch_done), .err(fetch_err)
  );

  cq_dispatch #(.PA_W(PA_W), .NCPU(NCPU)) u_disp (
    .clk(clk), .rst_n(rst_n), .start(fetch_done), .opcode(cmd[7:0]),
    .hnd_valid(hnd_valid), .hnd_ready(hnd_ready), .hnd_opcode(hnd_opcode),
    .hnd_done(hnd_done), .hnd_stall(hnd_stall), .recalc(recalc),
    .done(disp_done), .stall(disp_stall)
  );
endmodule

// File: rtl/cq_ring_proc_chk.sv
module cq_ring_proc_chk #(
  parameter int PA_W   = 48,
  parameter int SIZE_W = 8,
  parameter int NCPU   = 4,
  localparam int IDX_W = SIZE_W + 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [SIZE_W-1:0] size_fld,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              stalled,
  input logic              busy,
  input logic              advance,
  input logic              stall_set,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [PA_W-1:0]   mem_rd_addr,
  input logic              hnd_valid,
  input logic              hnd_ready,
  input logic [7:0]        hnd_opcode,
  input logic [NCPU-1:0]   recalc
);
  logic [IDX_W:0] lim;
  assign lim = {1'b0, size_fld, 7'b0} + (IDX_W+1)'(128);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (({1'b0, $past(rd_idx)} + (IDX_W+1)'(1) == $past(lim)) ?
                 (rd_idx == '0) : (rd_idx == $past(rd_idx) + IDX_W'(1))));

  p_start_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  p_start_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past({1'b0, rd_idx} < lim) && $past({1'b0, wr_idx} < lim)));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));

  p_offer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_valid && !hnd_ready) |=> (hnd_valid && $stable(hnd_opcode)));

  p_stall_keeps_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_set |=> (stalled && $stable(rd_idx)));

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|recalc) |=> !(|recalc));

  p_all_cpus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|recalc) |-> (&recalc));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> stalled);

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (!mem_rd_valid && !hnd_valid && !busy));
endmodule

bind cq_ring_proc cq_ring_proc_chk #(.PA_W(PA_W), .SIZE_W(SIZE_W), .NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .size_fld(size_fld), .wr_idx(wr_idx),
  .rd_idx(rd_idx), .stalled(stalled), .busy(busy), .advance(advance),
  .stall_set(stall_set), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .hnd_valid(hnd_valid), .hnd_ready(hnd_ready),
  .hnd_opcode(hnd_opcode), .recalc(recalc)
);

// File: tb/sim_cq_ring_proc.sv
module sim_cq_ring_proc;
  localparam int PA_W = 24;
  localparam int SIZE_W = 2;
  localparam int NCPU = 3;
  localparam int IDX_W = SIZE_W + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [SIZE_W-1:0] size_fld = '0;
  logic [PA_W-13:0] base_pfn = 12'h5A3;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [IDX_W-1:0] rd_idx;
  logic stalled;
  logic mem_rd_valid;
  logic mem_rd_ready = 1'b0;
  logic [PA_W-1:0] mem_rd_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic mem_rsp_err = 1'b0;
  logic hnd_valid;
  logic hnd_ready = 1'b0;
  logic [7:0] hnd_opcode;
  logic [PA_W-1:0] hnd_addr;
  logic [255:0] hnd_cmd;
  logic hnd_done = 1'b0;
  logic hnd_stall = 1'b0;
  logic [NCPU-1:0] recalc;

  always #2 clk = ~clk;

  cq_ring_proc #(.PA_W(PA_W), .SIZE_W(SIZE_W), .NCPU(NCPU)) u0 (.*);

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] opc_tab [512];
  int err_idx = -1;
  int err_beat = 0;
  int stall_idx = -1;
  int mreq = 0;
  int hcalls = 0;
  int bcasts = 0;

  function automatic int kind_of(input logic [7:0] o);
    if (o == 8'h03 || o == 8'h04 || o == 8'h08 || o == 8'h09 ||
        o == 8'h0A || o == 8'h0B || o == 8'h0F) return 0;
    if (o == 8'h05) return 1;
    if (o == 8'h0D) return 2;
    return 3;
  endfunction

  function automatic int base_addr();
    return int'(base_pfn) * 4096;
  endfunction

  function automatic logic [63:0] beat_data(input int addr);
    logic [63:0] d;
    int idx;
    idx = (addr - base_addr()) / 32;
    d = 64'hC0DE_7000_0000_0000 ^ 64'(addr);
    if ((addr % 32) == 0) d[7:0] = opc_tab[idx];
    return d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory responder and request monitor (R1)
  int mbeat = 0;
  bit mpend = 0;
  int maddr = 0;
  int mtick = 0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err = 1'b0;
    mtick++;
    if (!rst_n) begin
      mpend = 0; mbeat = 0; mem_rd_ready = 1'b0;
    end else begin
      if (mpend) begin
        int idx;
        idx = (maddr - base_addr()) / 32;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = beat_data(maddr);
        mem_rsp_err = (idx == err_idx) && (((maddr % 32) / 8) == err_beat);
        if (mem_rsp_err) mbeat = 0;
        mpend = 0;
      end
      mem_rd_ready = (mtick % 3) != 1;
      if (mem_rd_valid && mem_rd_ready) begin
        maddr = int'(mem_rd_addr);
        mreq++;
        check("R1 beat address", maddr, base_addr() + int'(rd_idx) * 32 + mbeat * 8);
        mbeat = (mbeat + 1) % 4;
        mpend = 1;
      end
    end
  end

  // handler model and offer monitor (R6, R7)
  bit hbusy = 0;
  int hwait = 0;
  int hidx = 0;
  int htick = 0;
  always @(negedge clk) begin
    hnd_done = 1'b0;
    hnd_stall = 1'b0;
    htick++;
    if (!rst_n) begin
      hbusy = 0; hwait = 0; hnd_ready = 1'b0;
    end else begin
      if (hbusy) begin
        if (hwait == 0) begin
          hnd_done = 1'b1;
          hnd_stall = (hidx == stall_idx);
          hbusy = 0;
        end else hwait--;
      end
      hnd_ready = !hbusy && ((htick % 2) == 0);
      if (hnd_valid && hnd_ready) begin
        int ea;
        logic [255:0] expc;
        hidx = int'(rd_idx);
        ea = base_addr() + hidx * 32;
        for (int k = 0; k < 4; k++) expc[64*k +: 64] = beat_data(ea + 8 * k);
        hcalls++;
        check("R6 offered opcode is a handler opcode", kind_of(hnd_opcode), 0);
        check("R6 offered opcode", int'(hnd_opcode), int'(opc_tab[hidx]));
        check("R6 offered address", int'(hnd_addr), ea);
        check("R1 offered command", int'(hnd_cmd == expc), 1);
        hbusy = 1;
        hwait = hidx % 3;
      end
    end
  end

  // recalc pulse monitor (R9)
  logic [NCPU-1:0] prev_rc = '0;
  always @(negedge clk) begin
    if (rst_n && recalc != '0) begin
      bcasts++;
      check("R9 all CPUs pulsed", int'(recalc), (1 << NCPU) - 1);
      check("R9 pulse one cycle wide", int'(prev_rc), 0);
    end
    prev_rc = recalc;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rd_idx == wr_idx || stalled) break;
    end
    repeat (6) @(negedge clk);
  endtask

  // expected handler and broadcast counts over count entries from first
  task automatic expect_counts(input int first, input int count, input int depth,
                               output int eh, output int eb);
    eh = 0; eb = 0;
    for (int i = 0; i < count; i++) begin
      int k;
      k = kind_of(opc_tab[(first + i) % depth]);
      if (k == 0) eh++;
      if (k == 2) eb++;
    end
  endtask

  initial begin
    int h0, b0, m0, eh, eb;
    for (int i = 0; i < 512; i++) opc_tab[i] = 8'(i);
    do_reset();
    @(negedge clk);
    // R12 reset state
    check("R12 rd_idx after reset", int'(rd_idx), 0);
    check("R12 stalled after reset", int'(stalled), 0);
    check("R12 no request after reset", int'(mem_rd_valid), 0);
    check("R12 no offer after reset", int'(hnd_valid), 0);
    check("R12 no recalc after reset", int'(recalc), 0);

    // R3: disabled queue does not move
    size_fld = 2'd1;
    wr_idx = 9'd5;
    repeat (60) @(negedge clk);
    check("R3 disabled rd_idx", int'(rd_idx), 0);
    check("R3 disabled no fetch", mreq, 0);

    // R6 R8 R9 R10: opcode sweep 0..199
    h0 = hcalls; b0 = bcasts;
    en = 1'b1;
    wr_idx = 9'd200;
    wait_quiet();
    expect_counts(0, 200, 256, eh, eb);
    check("R3 stops at write index", int'(rd_idx), 200);
    check("R6 R10 handler offers in sweep", hcalls - h0, eh);
    check("R8 R9 broadcast count in sweep", bcasts - b0, eb);
    check("R8 R10 no stall in sweep", int'(stalled), 0);

    // R2: wrap through 255 -> 0
    h0 = hcalls; b0 = bcasts;
    wr_idx = 9'd10;
    wait_quiet();
    expect_counts(200, 66, 256, eh, eb);
    check("R2 wrapped rd_idx", int'(rd_idx), 10);
    check("R2 handler offers across wrap", hcalls - h0, eh);
    check("R9 broadcasts across wrap", bcasts - b0, eb);

    // R4: write index beyond depth
    m0 = mreq;
    wr_idx = 9'd300;
    repeat (60) @(negedge clk);
    check("R4 wr out of range rd_idx", int'(rd_idx), 10);
    check("R4 wr out of range no fetch", mreq - m0, 0);
    wr_idx = 9'd130;
    wait_quiet();
    check("R4 resume after range fix", int'(rd_idx), 130);
    // R4: read index beyond a reduced depth
    m0 = mreq;
    size_fld = 2'd0;
    wr_idx = 9'd5;
    repeat (60) @(negedge clk);
    check("R4 rd out of range rd_idx", int'(rd_idx), 130);
    check("R4 rd out of range no fetch", mreq - m0, 0);
    size_fld = 2'd1;
    wr_idx = 9'd135;
    wait_quiet();
    check("R4 resume after depth restored", int'(rd_idx), 135);

    // R7 R11: handler stall
    opc_tab[140] = 8'h09;
    stall_idx = 140;
    h0 = hcalls;
    wr_idx = 9'd150;
    wait_quiet();
    expect_counts(135, 6, 256, eh, eb);
    check("R7 stall keeps rd_idx", int'(rd_idx), 140);
    check("R7 stalled flag", int'(stalled), 1);
    check("R7 offers up to stalling entry", hcalls - h0, eh);
    m0 = mreq; h0 = hcalls;
    wr_idx = 9'd160;
    repeat (80) @(negedge clk);
    check("R11 stalled stays", int'(stalled), 1);
    check("R11 rd_idx frozen", int'(rd_idx), 140);
    check("R11 no fetch while stalled", mreq - m0, 0);
    check("R11 no offer while stalled", hcalls - h0, 0);

    // R12 reset clears stall
    stall_idx = -1;
    wr_idx = 9'd0;
    size_fld = 2'd0;
    do_reset();
    @(negedge clk);
    check("R12 stall cleared by reset", int'(stalled), 0);
    check("R12 rd_idx cleared by reset", int'(rd_idx), 0);

    // R5: error on beat 2 of entry 3
    err_idx = 3; err_beat = 2;
    h0 = hcalls;
    wr_idx = 9'd8;
    wait_quiet();
    check("R5 rd_idx on failing entry", int'(rd_idx), 3);
    check("R5 stalled on fetch error", int'(stalled), 1);
    check("R5 failing entry not offered", hcalls - h0, 0);

    // R5: error on beat 0 of entry 5
    wr_idx = 9'd0;
    do_reset();
    err_idx = 5; err_beat = 0;
    h0 = hcalls;
    wr_idx = 9'd8;
    wait_quiet();
    expect_counts(0, 5, 128, eh, eb);
    check("R5 rd_idx on first-beat error", int'(rd_idx), 5);
    check("R5 stalled on first-beat error", int'(stalled), 1);
    check("R5 offers before error", hcalls - h0, eh);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule